// File: doc/BRIEF.md
# Packing write stream FIFO

This block turns a stream of narrow write items into whole 32-bit memory writes. A stream is opened with a 19-bit byte address. After that, each item is a byte, a word or a long, or a skip of one of those sizes. Each item is laid down at the current byte position and the position moves past it. Items pack little-endian: the lowest byte of an item goes to the lowest byte address.

Each finished long is placed in a small queue together with a 4-bit byte-lane enable. The queue then writes it to consecutive long addresses, so lanes that were skipped or filtered keep their old memory contents. An optional filter, chosen when the stream is opened, drops every 0xFF byte. This lets 0xFF act as a transparent value.

Opening a new stream first pushes out any long still partly filled from the previous stream. Software watches the drained output to learn when everything queued has reached memory. The packer is a two-state machine:
- PK_IDLE: the state after reset. No stream is open, and items are consumed and discarded.
- PK_STREAM: a stream is open.

There are two transitions:
- open (PK_IDLE to PK_STREAM, on an accepted init).
- reopen (PK_STREAM to PK_STREAM, on an accepted init, with a flush of the pending partial long).

Top module: `wpk_stream_top`

## Requirements
- R1: After reset, drained is 1, mem_we is 0 and in_ready is 1.
- R2: An init is accepted when init_valid and in_ready are both 1. Its address bits [18:2] give the first long address and bits [1:0] give the starting byte lane. Items accepted before the first init write nothing. When init_valid and item_valid are both 1, the init is taken and the item is not consumed.
- R3: item_size codes are 0 = byte, 1 = word, 2 or 3 = long. Byte k of item_data (bits 8k+7..8k) is written at byte address position+k, and the position then advances by the item size. Items may cross a long boundary at any lane.
- R4: With item_skip = 1, the position advances by the item size and the lanes covered are not written (their enables are 0).
- R5: filter_en is sampled at init. While it is set, every byte of a written item equal to 0xFF is left unwritten, but the position still advances past it. While it is clear, 0xFF bytes are written normally.
- R6: An init pushes the pending partial long if any of its lanes is enabled. No memory write ever has mem_be = 0.
- R7: Each completed long goes to the long address after the previous one. The long address wraps from 0x1FFFF to 0.
- R8: The queue holds QUEUE_DEPTH (8) longs. in_ready is 0 while it is full, and nothing is accepted then.
- R9: mem_we is held with mem_addr, mem_data and mem_be stable until mem_ready is 1. Longs reach memory in the order they were completed.
- R10: drained is 1 exactly when the queue holds no long.
- R11: When mem_ready stays 1, items of any size at any lane are accepted on consecutive cycles without in_ready falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_valid | input | 1 | Open a new stream |
| init_addr | input | 19 | Starting byte address |
| filter_en | input | 1 | Suppress 0xFF bytes in the new stream |
| item_valid | input | 1 | Item present |
| item_size | input | 2 | 0 byte, 1 word, 2/3 long |
| item_skip | input | 1 | Advance without writing |
| item_data | input | 32 | Item bytes, lowest address in bits 7:0 |
| in_ready | output | 1 | Init or item may be accepted this cycle |
| mem_we | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_addr | output | 17 | Long address |
| mem_data | output | 32 | Long data |
| mem_be | output | 4 | Byte-lane write enables |
| drained | output | 1 | Queue empty, all completed longs written |

## Verification
The hardest condition to reach from the ports is a full queue: the memory drains one long per cycle, and the packer produces at most one long per cycle. The bench holds mem_ready low while it sends lane-0 longs until in_ready drops. It then releases the memory and compares the whole written image. A long mixed run toggles mem_ready on a fixed pattern, so that pushes, pops and stalls coincide. Lane, size and skip combinations are swept and checked against a byte-level model.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    localparam int unsigned BYTE_AW = 19;
    localparam int unsigned LONG_AW = BYTE_AW - 2;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_WORD     = 2'd1,
        SZ_LONG     = 2'd2,
        SZ_LONG_ALT = 2'd3
    } item_size_e;

    typedef enum logic {
        PK_IDLE   = 1'b0,
        PK_STREAM = 1'b1
    } pk_state_e;

    typedef struct packed {
        logic [LONG_AW-1:0] addr;
        logic [31:0]        data;
        logic [3:0]         be;
    } packed_long_t;

endpackage

// File: rtl/wpk_queue.sv
module wpk_queue #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 53
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign empty     = (count_q == '0);
    assign full      = (count_q == CW'(DEPTH));
    assign out_valid = !empty;
    assign out_data  = slots[rd_q];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count_q < CW'(DEPTH)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count_q != '0));

endmodule

// File: rtl/wpk_packer.sv
module wpk_packer
    import wpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_fire,
    input  logic [BYTE_AW-1:0] init_addr,
    input  logic               filter_en,
    input  logic               item_fire,
    input  logic [1:0]         item_size,
    input  logic               item_skip,
    input  logic [31:0]        item_data,
    output logic               push,
    output packed_long_t       push_entry
);
    pk_state_e          st_q, st_d;
    logic [1:0]         pos_q, pos_d;
    logic [LONG_AW-1:0] laddr_q, laddr_d;
    logic [31:0]        acc_data_q, acc_data_d;
    logic [3:0]         acc_be_q, acc_be_d;
    logic               filt_q, filt_d;

    logic [2:0]  span;
    logic [2:0]  end_pos;
    logic [7:0]  lane_val [8];
    logic [7:0]  lane_in;
    logic [7:0]  win_be;
    logic [63:0] win_data;
    logic [31:0] mrg_data;
    logic [3:0]  mrg_be;

    // Window of eight byte lanes: the current long and the one after it.
    always_comb begin
        unique case (item_size_e'(item_size))
            SZ_BYTE: span = 3'd1;
            SZ_WORD: span = 3'd2;
            default: span = 3'd4;
        endcase
        end_pos = {1'b0, pos_q} + span;
        for (int i = 0; i < 8; i++) begin
            lane_in[i]  = (3'(i) >= {1'b0, pos_q}) && ((3'(i) - {1'b0, pos_q}) < span);
            lane_val[i] = item_data[8*(2'(3'(i) - {1'b0, pos_q})) +: 8];
            win_be[i]   = lane_in[i] && !item_skip && !(filt_q && (lane_val[i] == 8'hFF));
            win_data[8*i +: 8] = win_be[i] ? lane_val[i] : 8'h00;
        end
        for (int l = 0; l < 4; l++) begin
            mrg_be[l]          = acc_be_q[l] | win_be[l];
            mrg_data[8*l +: 8] = win_be[l] ? win_data[8*l +: 8] : acc_data_q[8*l +: 8];
        end
    end

    // Next-state and output process.
    always_comb begin
        st_d       = st_q;
        pos_d      = pos_q;
        laddr_d    = laddr_q;
        acc_data_d = acc_data_q;
        acc_be_d   = acc_be_q;
        filt_d     = filt_q;
        push       = 1'b0;
        push_entry = '{addr: laddr_q, data: acc_data_q, be: acc_be_q};
        unique case (st_q)
            PK_IDLE: begin
                if (init_fire) begin
                    st_d       = PK_STREAM;
                    laddr_d    = init_addr[BYTE_AW-1:2];
                    pos_d      = init_addr[1:0];
                    acc_data_d = '0;
                    acc_be_d   = '0;
                    filt_d     = filter_en;
                end
            end
            PK_STREAM: begin
                if (init_fire) begin
                    push       = (acc_be_q != 4'd0);
                    laddr_d    = init_addr[BYTE_AW-1:2];
                    pos_d      = init_addr[1:0];
                    acc_data_d = '0;
                    acc_be_d   = '0;
                    filt_d     = filter_en;
                end else if (item_fire) begin
                    pos_d = end_pos[1:0];
                    if (end_pos[2]) begin
                        push       = (mrg_be != 4'd0);
                        push_entry = '{addr: laddr_q, data: mrg_data, be: mrg_be};
                        laddr_d    = laddr_q + 1'b1;
                        acc_data_d = win_data[63:32];
                        acc_be_d   = win_be[7:4];
                    end else begin
                        acc_data_d = mrg_data;
                        acc_be_d   = mrg_be;
                    end
                end
            end
            default: st_d = PK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= PK_IDLE;
            pos_q      <= '0;
            laddr_q    <= '0;
            acc_data_q <= '0;
            acc_be_q   <= '0;
            filt_q     <= 1'b0;
        end else begin
            st_q       <= st_d;
            pos_q      <= pos_d;
            laddr_q    <= laddr_d;
            acc_data_q <= acc_data_d;
            acc_be_q   <= acc_be_d;
            filt_q     <= filt_d;
        end
    end

    // R3
    lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd0) |-> (acc_be_q == 4'd0));

    // R2
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_IDLE) |-> (acc_be_q == 4'd0));

endmodule

// File: rtl/wpk_stream_top.sv
module wpk_stream_top
    import wpk_pkg::*;
#(
    parameter int unsigned QUEUE_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_valid,
    input  logic [18:0]         init_addr,
    input  logic                filter_en,
    input  logic                item_valid,
    input  logic [1:0]          item_size,
    input  logic                item_skip,
    input  logic [31:0]         item_data,
    output logic                in_ready,
    output logic                mem_we,
    input  logic                mem_ready,
    output logic [16:0]         mem_addr,
    output logic [31:0]         mem_data,
    output logic [3:0]          mem_be,
    output logic                drained
);
    localparam int unsigned EW = $bits(packed_long_t);

    logic         init_fire, item_fire;
    logic         push, pop, q_full, q_empty, q_valid;
    packed_long_t push_entry, head;
    logic [EW-1:0] head_bits;

    assign init_fire = init_valid && in_ready;
    assign item_fire = item_valid && in_ready && !init_valid;

    wpk_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_fire  (init_fire),
        .init_addr  (init_addr),
        .filter_en  (filter_en),
        .item_fire  (item_fire),
        .item_size  (item_size),
        .item_skip  (item_skip),
        .item_data  (item_data),
        .push       (push),
        .push_entry (push_entry)
    );

    wpk_queue #(
        .DEPTH (QUEUE_DEPTH),
        .W     (EW)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_entry),
        .pop       (pop),
        .out_valid (q_valid),
        .out_data  (head_bits),
        .full      (q_full),
        .empty     (q_empty)
    );

    assign head     = packed_long_t'(head_bits);
    assign pop      = q_valid && mem_ready;
    assign in_ready = !q_full;
    assign mem_we   = q_valid;
    assign mem_addr = head.addr;
    assign mem_data = head.data;
    assign mem_be   = head.be;
    assign drained  = q_empty;

    // R6
    mem_be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != 4'd0));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

endmodule

// File: tb/wpk_stream_top_bench.sv
module wpk_stream_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_valid = 1'b0;
    logic [18:0] init_addr = '0;
    logic        filter_en = 1'b0;
    logic        item_valid = 1'b0;
    logic [1:0]  item_size = '0;
    logic        item_skip = 1'b0;
    logic [31:0] item_data = '0;
    logic        in_ready, mem_we, drained;
    logic        mem_ready;
    logic [16:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;

    logic        ready_set = 1'b1;
    logic        stress_on = 1'b0;
    logic [3:0]  pat_cnt = '0;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;

    logic [7:0] exp_mem [int];
    logic [7:0] act_mem [int];
    logic [18:0] cur;
    logic        mfilt;
    logic        running = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) pat_cnt <= pat_cnt + 1'b1;
    assign mem_ready = stress_on ? (pat_cnt[0] ^ pat_cnt[2]) : ready_set;

    wpk_stream_top u_wpk_stream_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .init_addr  (init_addr),
        .filter_en  (filter_en),
        .item_valid (item_valid),
        .item_size  (item_size),
        .item_skip  (item_skip),
        .item_data  (item_data),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_be     (mem_be),
        .drained    (drained)
    );

    // Memory model and port monitor, sampled mid-cycle.
    logic        was_stalled = 1'b0;
    logic [16:0] st_addr;
    logic [31:0] st_data;
    logic [3:0]  st_be;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (was_stalled) begin
                checks++;
                if (!mem_we || mem_addr != st_addr || mem_data != st_data || mem_be != st_be) begin
                    fails++;
                    $display("FAIL R9 stall hold: got we=%0b %h/%h/%h exp %h/%h/%h",
                             mem_we, mem_addr, mem_data, mem_be, st_addr, st_data, st_be);
                end
            end
            was_stalled = mem_we && !mem_ready;
            st_addr = mem_addr; st_data = mem_data; st_be = mem_be;
            if (mem_we && mem_ready) begin
                wr_count++;
                checks++;
                if (mem_be == 4'd0) begin
                    fails++;
                    $display("FAIL R6 write with empty enables: got be=%h exp nonzero", mem_be);
                end
                for (int l = 0; l < 4; l++) begin
                    if (mem_be[l]) act_mem[int'({mem_addr, 2'(l)})] = mem_data[8*l +: 8];
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic do_init(input logic [18:0] a, input logic f);
        init_valid = 1'b1; init_addr = a; filter_en = f; item_valid = 1'b0;
        forever begin
            #1;
            if (in_ready) begin @(posedge clk); break; end
            @(negedge clk);
        end
        @(negedge clk);
        init_valid = 1'b0;
        cur = a; mfilt = f; running = 1'b1;
    endtask

    task automatic send_item(input logic [1:0] sz, input logic sk, input logic [31:0] d, output int waits);
        int n;
        waits = 0;
        item_valid = 1'b1; item_size = sz; item_skip = sk; item_data = d;
        forever begin
            #1;
            if (in_ready) begin @(posedge clk); break; end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        if (running) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = d[8*k +: 8];
                if (!sk && !(mfilt && b == 8'hFF)) exp_mem[int'(19'(cur + 19'(k)))] = b;
            end
            cur = 19'(cur + 19'(n));
        end
    endtask

    task automatic idle();
        item_valid = 1'b0; init_valid = 1'b0;
    endtask

    task automatic finish_cmp(input string tag);
        logic ok;
        do_init(19'h60000, 1'b0);
        idle();
        for (int k = 0; k < 400 && !drained; k++) @(negedge clk);
        ok = 1'b1;
        foreach (exp_mem[a]) begin
            if (!act_mem.exists(a)) begin
                if (ok) $display("FAIL %s: byte %h got unwritten exp %h", tag, a, exp_mem[a]);
                ok = 1'b0;
            end else if (act_mem[a] != exp_mem[a]) begin
                if (ok) $display("FAIL %s: byte %h got %h exp %h", tag, a, act_mem[a], exp_mem[a]);
                ok = 1'b0;
            end
        end
        foreach (act_mem[a]) begin
            if (!exp_mem.exists(a)) begin
                if (ok) $display("FAIL %s: byte %h got written %h exp untouched", tag, a, act_mem[a]);
                ok = 1'b0;
            end
        end
        checks++;
        if (!ok) fails++;
        exp_mem.delete();
        act_mem.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got no finish exp finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w, tw, idx;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 drained", 32'(drained), 32'd1);
        check("R1 mem_we", 32'(mem_we), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd1);

        // R2 items before any init write nothing
        @(negedge clk);
        send_item(2'd2, 1'b0, 32'h0BADF00D, w);
        send_item(2'd2, 1'b0, 32'h12345678, w);
        send_item(2'd0, 1'b0, 32'h000000AA, w);
        idle();
        repeat (6) @(negedge clk);
        check("R2 no write before init", 32'(wr_count), 32'd0);

        // R3/R4 sweep of start lane, size and skip
        idx = 0;
        for (int ln = 0; ln < 4; ln++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sk = 0; sk < 2; sk++) begin
                    do_init(19'(19'h01000 + 19'(idx * 32) + 19'(ln)), 1'b0);
                    send_item(2'(sz), sk[0], 32'hA1FF_C3D4 ^ 32'(idx), w);
                    send_item(2'd2, 1'b0, 32'h5566_7788 + 32'(idx), w);
                    send_item(2'(sz), 1'b0, 32'h99AB_CDEF, w);
                    send_item(2'd0, 1'b0, 32'h0000_0042, w);
                    idle();
                    finish_cmp(sk ? "R4 skip sweep" : "R3 pack sweep");
                    idx++;
                end
            end
        end

        // R5 filter on, 0xFF bytes at each lane
        for (int ln = 0; ln < 4; ln++) begin
            for (int sz = 0; sz < 3; sz++) begin
                do_init(19'(19'h03000 + 19'(idx * 32) + 19'(ln)), 1'b1);
                send_item(2'(sz), 1'b0, 32'hFFA5_FF3C, w);
                send_item(2'd2, 1'b0, 32'h00FF_12FF, w);
                send_item(2'(sz), 1'b0, 32'hFFFF_FFFF, w);
                send_item(2'd1, 1'b0, 32'h0000_FF77, w);
                idle();
                finish_cmp("R5 filter");
                idx++;
            end
        end

        // R6 partial long flushed by init
        do_init(19'h02201, 1'b0);
        send_item(2'd0, 1'b0, 32'h0000_005A, w);
        idle();
        repeat (4) @(negedge clk);
        check("R6 partial held before init", 32'(drained), 32'd1);
        finish_cmp("R6 flush");

        // R7 long address wrap
        do_init(19'h7FFFE, 1'b0);
        send_item(2'd2, 1'b0, 32'hCAFE_BABE, w);
        send_item(2'd2, 1'b0, 32'h1234_5678, w);
        idle();
        finish_cmp("R7 wrap");

        // R8 full queue backpressure
        ready_set = 1'b0;
        do_init(19'h04000, 1'b0);
        tw = 0;
        for (int k = 0; k < 8; k++) begin
            send_item(2'd2, 1'b0, 32'h7000_0000 + 32'(k), w);
            tw += w;
        end
        idle();
        #1;
        check("R8 eight accepted without wait", 32'(tw), 32'd0);
        check("R8 in_ready low when full", 32'(in_ready), 32'd0);
        check("R10 drained low when full", 32'(drained), 32'd0);
        check("R9 request held", 32'(mem_we), 32'd1);
        repeat (3) @(negedge clk);
        ready_set = 1'b1;
        send_item(2'd2, 1'b0, 32'h7000_0008, w);
        idle();
        finish_cmp("R8 full queue");
        #1;
        check("R10 drained after flush", 32'(drained), 32'd1);

        // R11 straddling items back to back
        do_init(19'h05003, 1'b0);
        tw = 0;
        for (int k = 0; k < 16; k++) begin
            send_item(2'd1, 1'b0, 32'h0000_1000 + 32'(k * 3), w);
            tw += w;
        end
        for (int k = 0; k < 8; k++) begin
            send_item(2'd2, 1'b0, 32'h8800_0000 + 32'(k), w);
            tw += w;
        end
        idle();
        check("R11 no stall on straddle", 32'(tw), 32'd0);
        finish_cmp("R11 straddle data");

        // R9 mixed stream under memory stalls
        stress_on = 1'b1;
        lfsr = 16'hACE1;
        for (int r = 0; r < 3; r++) begin
            do_init(19'(19'h06000 + 19'(r * 512) + 19'(r)), r[0]);
            for (int k = 0; k < 60; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                send_item(lfsr[1:0], lfsr[2] & lfsr[3],
                          {lfsr[15:8], 8'hFF, lfsr[7:0], 8'(k)}, w);
            end
            idle();
            stress_on = 1'b0;
            finish_cmp("R9 mixed stalls");
            stress_on = 1'b1;
        end
        stress_on = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule